// File: doc/BRIEF.md
# Microcoded memory cycle sequencer

This block runs memory access cycles from a small writable pattern store. Each
entry of the store is a 14-bit control word. One word is executed per clock.
A request names the entry where a pattern begins. From then on, the word at the
program counter drives the external strobes, two general-purpose lines, the
address-source select and the active-low transfer acknowledge. Words are
executed in order until a word marked as final completes.

Sequencing inside a pattern is controlled by flags in the words themselves:

- **Loop markers** bound a body that is repeated a count of times set by a mode input.
- **Exception enable**, set per word, lets a transfer error, hard reset or soft reset redirect execution to a fixed exception pattern.
- **Next-address** steps the burst address by the port size.
- **Wait enable** reuses the general-purpose-line-4 bit. When a mode input selects it, an external wait input freezes the sequencer and every output it drives.

Top module: `mcs_sequencer`

## Requirements
- R1: Out of reset and whenever idle: `busy_o`=0, `strb_n_o`=4'hF, `ack_n_o`=1, `gpl4_o`=`gpl5_early_o`=`gpl5_late_o`=0 and `addr_o`=0.
- R2: A request seen while idle at a clock edge makes the word at `req_start_i` current from that edge. Each later edge makes the next word current. A request while busy has no effect.
- R3: A word with bit 13 (final) set is the last word of a pattern. After it completes, the block is idle at the next edge.
- R4: The first word carrying bit 7 (loop marker) opens a loop. The next marked word closes it. The body, from the opening word to the closing word inclusive, runs `mode_loops_i` times, with 0 treated as 1. Markers after the loop has finished are ignored. The count is reloaded at every pattern start.
- R5: If bit 8 (exception enable) of the current word is set and any of `tea_i`, `hrst_i`, `srst_i` is high, the next current word is entry `EXC_ADDR` (default 48). This takes precedence over the final bit and over loop branches.
- R6: When bit 8 is clear, the exception inputs are ignored and execution continues with the following word.
- R7: Bits 10:9 choose `addr_o`:
  - 00: the burst address.
  - 10: the burst address shifted right by `mode_rowsh_i`.
  - 11: `mar_i`.
  - 01 (reserved): treated as 00.
- R8: In a burst pattern (`req_burst_i`=1 at start), a word with bit 11 (next address) set adds a step to the burst address, visible from the next word. The step is 1, 2 or 4 for `psize_i` values 0, 1 and 2; a value of 3 steps by 4.
- R9: In a non-burst pattern, bit 11 has no effect on the address.
- R10: `ack_n_o` equals bit 12 of the current word; 0 means acknowledge asserted.
- R11: With `mode_g4dis_i`=0, `gpl4_o` equals bit 4. With `mode_g4dis_i`=1, `gpl4_o` is driven 1 while busy and bit 4 acts as wait enable.
- R12: While the current word has wait enable and `wait_i` is high, the program counter, the burst address and all outputs hold.
- R13: `gpl5_early_o` follows bit 5 (phases 1 to 3) and `gpl5_late_o` follows bit 6 (phase 4). `strb_n_o` follows bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start-pattern request |
| req_start_i | input | 6 | First entry of the requested pattern |
| req_addr_i | input | 32 | Requester address, loaded at start |
| req_burst_i | input | 1 | Request is a burst transfer |
| psize_i | input | 2 | Port size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| mar_i | input | 32 | Memory-address register contents |
| mode_loops_i | input | 4 | Loop iteration count |
| mode_rowsh_i | input | 5 | Row-address shift amount |
| mode_g4dis_i | input | 1 | Repurpose bit 4 as wait enable |
| wait_i | input | 1 | External wait |
| tea_i | input | 1 | Transfer error |
| hrst_i | input | 1 | Hard reset exception |
| srst_i | input | 1 | Soft reset exception |
| pw_en_i | input | 1 | Pattern store write enable |
| pw_addr_i | input | 6 | Pattern store write entry |
| pw_data_i | input | 14 | Pattern store write data |
| busy_o | output | 1 | A pattern is executing |
| strb_n_o | output | 4 | Memory strobes, active low |
| gpl4_o | output | 1 | General-purpose line 4 |
| gpl5_early_o | output | 1 | General-purpose line 5, phases 1 to 3 |
| gpl5_late_o | output | 1 | General-purpose line 5, phase 4 |
| addr_o | output | 32 | Selected memory address |
| ack_n_o | output | 1 | Transfer acknowledge, active low |

## Verification
Single-word patterns cover field decoding. They use different strobe codes and all four address-select codes, and both settings of the line-4 mode, so that a swapped field, a wrong address source or a missing line-4 override each give a distinct output.

Multi-word patterns cover the sequencing rules:

- A loop run with a count of 3 and again with 0 separates correct body repetition from an off-by-one, from re-treating the opening word as a closing marker, and from a stale count.
- An exception raised on an enabled word and on a non-enabled word shows whether the per-word gate works.
- Bursts at each of the three port sizes, and one non-burst run, separate the step scaling from the burst gating.
- Wait is applied with the wait-enable mode on and off, which distinguishes a freeze from a line-4 value.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int STRB_W = 4;

  typedef struct packed {
    logic              last;    // 13
    logic              ack_n;   // 12
    logic              nxt;     // 11
    logic [1:0]        amux;    // 10:9
    logic              exc_en;  // 8
    logic              loop_mk; // 7
    logic              g5_late; // 6
    logic              g5_early;// 5
    logic              g4;      // 4
    logic [STRB_W-1:0] strb_n;  // 3:0
  } mcs_word_t;

  localparam int WORD_W = $bits(mcs_word_t);

  // burst step for a port-size code: 0 -> 1 byte, 1 -> 2, 2/3 -> 4
  function automatic logic [2:0] step_of(input logic [1:0] psize);
    case (psize)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/mcs_pram.sv
module mcs_pram
  import mcs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  mcs_word_t     wdata,
  input  logic [PW-1:0] raddr,
  output mcs_word_t     rdata
);
  mcs_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mcs_loopctl.sv
module mcs_loopctl #(
  parameter int PW    = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             adv,
  input  logic             mark,
  input  logic [PW-1:0]    pc,
  input  logic [CNT_W-1:0] n_iter,
  output logic             jump,
  output logic [PW-1:0]    tgt
);
  logic             in_loop, done;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    lstart;

  // events brought out for checking
  logic open_ev, close_ev;
  assign open_ev  = adv & mark & ~in_loop & ~done;
  assign close_ev = adv & mark & in_loop & (pc != lstart);

  assign jump = in_loop & mark & (pc != lstart) & (cnt > CNT_W'(1));
  assign tgt  = lstart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_loop <= 1'b0;
      done    <= 1'b0;
      cnt     <= CNT_W'(1);
      lstart  <= '0;
    end else if (restart) begin
      in_loop <= 1'b0;
      done    <= 1'b0;
      cnt     <= (n_iter == '0) ? CNT_W'(1) : n_iter;
    end else if (open_ev) begin
      in_loop <= 1'b1;
      lstart  <= pc;
    end else if (close_ev) begin
      if (cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
      else begin
        in_loop <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  a_r4_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    in_loop |-> (cnt != '0));
  a_r4_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> !in_loop);
endmodule

// File: rtl/mcs_addrgen.sv
module mcs_addrgen
  import mcs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   ld_addr,
  input  logic            ld_burst,
  input  logic            adv,
  input  logic            nxt,
  input  logic [1:0]      psize,
  input  logic [1:0]      amux,
  input  logic [SH_W-1:0] rowsh,
  input  logic [AW-1:0]   mar,
  output logic [AW-1:0]   addr
);
  logic [AW-1:0] a_q;
  logic          burst_q;
  logic          inc;
  logic [AW-1:0] stepv;

  assign inc   = adv & nxt & burst_q;
  assign stepv = AW'(step_of(psize));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      burst_q <= 1'b0;
    end else if (load) begin
      a_q     <= ld_addr;
      burst_q <= ld_burst;
    end else if (inc) begin
      a_q <= a_q + stepv;
    end
  end

  always_comb begin
    case (amux)
      2'b10:   addr = a_q >> rowsh;
      2'b11:   addr = mar;
      default: addr = a_q;
    endcase
  end

  a_r8_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (a_q == $past(a_q) + $past(stepv)));
  a_r9_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !burst_q && !load) |=> $stable(a_q));
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int AW       = 32,
  parameter int CNT_W    = 4,
  parameter int SH_W     = 5,
  parameter int EXC_ADDR = 48,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [PW-1:0]     req_start_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              req_burst_i,
  input  logic [1:0]        psize_i,
  input  logic [AW-1:0]     mar_i,
  input  logic [CNT_W-1:0]  mode_loops_i,
  input  logic [SH_W-1:0]   mode_rowsh_i,
  input  logic              mode_g4dis_i,
  input  logic              wait_i,
  input  logic              tea_i,
  input  logic              hrst_i,
  input  logic              srst_i,
  input  logic              pw_en_i,
  input  logic [PW-1:0]     pw_addr_i,
  input  logic [WORD_W-1:0] pw_data_i,
  output logic              busy_o,
  output logic [STRB_W-1:0] strb_n_o,
  output logic              gpl4_o,
  output logic              gpl5_early_o,
  output logic              gpl5_late_o,
  output logic [AW-1:0]     addr_o,
  output logic              ack_n_o
);
  localparam logic [PW-1:0] EXC_PC = PW'(EXC_ADDR);

  logic          run;
  logic [PW-1:0] pc;
  mcs_word_t     cur;
  logic [AW-1:0] sel_addr;

  // named internal events
  logic exc_any, stall, step, exc_take, fin, adv, start, jump;
  logic [PW-1:0] tgt;

  assign exc_any  = tea_i | hrst_i | srst_i;
  assign stall    = run & mode_g4dis_i & cur.g4 & wait_i;
  assign step     = run & ~stall;
  assign exc_take = step & cur.exc_en & exc_any;
  assign fin      = step & ~exc_take & cur.last;
  assign adv      = step & ~exc_take & ~cur.last;
  assign start    = req_i & ~run;

  mcs_pram #(.DEPTH(DEPTH)) u_pram (
    .clk(clk), .we(pw_en_i), .waddr(pw_addr_i),
    .wdata(mcs_word_t'(pw_data_i)), .raddr(pc), .rdata(cur)
  );

  mcs_loopctl #(.PW(PW), .CNT_W(CNT_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .restart(start | exc_take), .adv(adv),
    .mark(cur.loop_mk), .pc(pc), .n_iter(mode_loops_i),
    .jump(jump), .tgt(tgt)
  );

  mcs_addrgen #(.AW(AW), .SH_W(SH_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .ld_addr(req_addr_i),
    .ld_burst(req_burst_i), .adv(step), .nxt(cur.nxt), .psize(psize_i),
    .amux(cur.amux), .rowsh(mode_rowsh_i), .mar(mar_i), .addr(sel_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      pc  <= '0;
    end else if (start) begin
      run <= 1'b1;
      pc  <= req_start_i;
    end else if (exc_take) begin
      pc <= EXC_PC;
    end else if (fin) begin
      run <= 1'b0;
    end else if (adv) begin
      pc <= jump ? tgt : pc + PW'(1);
    end
  end

  assign busy_o       = run;
  assign strb_n_o     = run ? cur.strb_n : '1;
  assign gpl4_o       = run & (mode_g4dis_i | cur.g4);
  assign gpl5_early_o = run & cur.g5_early;
  assign gpl5_late_o  = run & cur.g5_late;
  assign ack_n_o      = run ? cur.ack_n : 1'b1;
  assign addr_o       = run ? sel_addr : '0;

  a_r12_freeze_pc: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc) && run));
  a_r5_exc_branch: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (pc == EXC_PC && run));
  a_r3_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !run);
  a_r2_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !exc_take && !fin && !stall && !jump) |=> (pc == $past(pc) + PW'(1)));
endmodule

// File: tb/mcs_sequencer_tb.sv
module mcs_sequencer_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_i, req_burst_i, mode_g4dis_i, wait_i, tea_i, hrst_i, srst_i, pw_en_i;
  logic [5:0] req_start_i, pw_addr_i;
  logic [31:0] req_addr_i, mar_i;
  logic [1:0] psize_i;
  logic [3:0] mode_loops_i;
  logic [4:0] mode_rowsh_i;
  logic [13:0] pw_data_i;
  logic busy_o, gpl4_o, gpl5_early_o, gpl5_late_o, ack_n_o;
  logic [3:0] strb_n_o;
  logic [31:0] addr_o;

  int n_chk = 0, n_bad = 0;

  localparam logic [31:0] REQA = 32'h1234_5670;
  localparam logic [31:0] MARV = 32'hCAFE_0001;

  mcs_sequencer u_dut (.*);

  typedef struct packed {
    logic [13:0] w; logic dis; logic [3:0] strb;
    logic ack; logic g4; logic g5e; logic g5l; logic [1:0] src;
  } vec_t;
  // src: 0 = column, 1 = row, 2 = address register
  localparam vec_t VEC [4] = '{
    '{14'h201E, 1'b0, 4'hE, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    '{14'h3425, 1'b0, 4'h5, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1},
    '{14'h2653, 1'b1, 4'h3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2},
    '{14'h320F, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0}
  };

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [13:0] d);
    pw_en_i = 1'b1; pw_addr_i = a; pw_data_i = d; tick(); pw_en_i = 1'b0;
  endtask

  task automatic go(input logic [5:0] a, input logic burst);
    req_i = 1'b1; req_start_i = a; req_burst_i = burst; tick(); req_i = 1'b0;
  endtask

  task automatic idle_chk(input string rq);
    chk(rq, {busy_o, strb_n_o, ack_n_o, gpl4_o, gpl5_early_o, gpl5_late_o},
        {1'b0, 4'hF, 1'b1, 3'b000});
    chk(rq, addr_o, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 0; req_burst_i = 0; mode_g4dis_i = 0; wait_i = 0;
    tea_i = 0; hrst_i = 0; srst_i = 0; pw_en_i = 0; req_start_i = 0; pw_addr_i = 0;
    req_addr_i = REQA; mar_i = MARV; psize_i = 2; mode_loops_i = 0;
    mode_rowsh_i = 5'd8; pw_data_i = 0;
    tick(); tick();
    idle_chk("R1 reset");
    rst_n = 1'b1; tick();
    idle_chk("R1 after reset");

    // table of single-word patterns: field decoding
    for (int i = 0; i < 4; i++) begin
      logic [31:0] ea;
      wr(6'd0, VEC[i].w);
      mode_g4dis_i = VEC[i].dis;
      go(6'd0, 1'b0);
      ea = (VEC[i].src == 2'd0) ? REQA : (VEC[i].src == 2'd1) ? (REQA >> 8) : MARV;
      chk("R13 strobes", strb_n_o, VEC[i].strb);
      chk("R10 ack", ack_n_o, VEC[i].ack);
      chk("R11 gpl4", gpl4_o, VEC[i].g4);
      chk("R13 gpl5", {gpl5_early_o, gpl5_late_o}, {VEC[i].g5e, VEC[i].g5l});
      chk("R7 addr select", addr_o, ea);
      tick();
      idle_chk("R3 idle after final");
    end
    mode_g4dis_i = 0;

    // R2 sequencing, request while busy ignored
    wr(6'd8, 14'h1001); wr(6'd9, 14'h1002); wr(6'd10, 14'h3004);
    go(6'd8, 1'b0);
    chk("R2 first word", strb_n_o, 4'h1);
    req_i = 1'b1; req_start_i = 6'd0; tick(); req_i = 1'b0;
    chk("R2 busy request ignored", strb_n_o, 4'h2);
    tick(); chk("R2 third word", strb_n_o, 4'h4);
    tick(); idle_chk("R3 end");

    // R4 loop
    wr(6'd16, 14'h1001); wr(6'd17, 14'h1082); wr(6'd18, 14'h1003);
    wr(6'd19, 14'h1084); wr(6'd20, 14'h3005);
    begin
      logic [3:0] e3 [11] = '{1, 2, 3, 4, 2, 3, 4, 2, 3, 4, 5};
      logic [3:0] e0 [5]  = '{1, 2, 3, 4, 5};
      mode_loops_i = 4'd3; go(6'd16, 1'b0);
      for (int k = 0; k < 11; k++) begin chk("R4 loop x3", strb_n_o, e3[k]); tick(); end
      idle_chk("R4 loop x3 end");
      mode_loops_i = 4'd0; go(6'd16, 1'b0);
      for (int k = 0; k < 5; k++) begin chk("R4 loop count 0", strb_n_o, e0[k]); tick(); end
      idle_chk("R4 loop count 0 end");
    end

    // R5 exception branch, R6 gated
    wr(6'd24, 14'h1101); wr(6'd25, 14'h3002); wr(6'd48, 14'h3008);
    go(6'd24, 1'b0); tea_i = 1'b1; tick(); tea_i = 1'b0;
    chk("R5 tea branch", strb_n_o, 4'h8);
    tick(); idle_chk("R5 exception pattern ends");
    go(6'd24, 1'b0); srst_i = 1'b1; tick(); srst_i = 1'b0;
    chk("R5 srst branch", strb_n_o, 4'h8);
    tick();
    wr(6'd28, 14'h1001); wr(6'd29, 14'h3002);
    go(6'd28, 1'b0); hrst_i = 1'b1; tick(); hrst_i = 1'b0;
    chk("R6 exception ignored", strb_n_o, 4'h2);
    tick(); idle_chk("R6 end");

    // R8 burst steps, R9 non-burst
    wr(6'd32, 14'h1801); wr(6'd33, 14'h1802); wr(6'd34, 14'h3004);
    for (int p = 0; p < 3; p++) begin
      logic [31:0] s;
      psize_i = 2'(p);
      s = (p == 0) ? 32'd1 : (p == 1) ? 32'd2 : 32'd4;
      go(6'd32, 1'b1);
      chk("R8 burst base", addr_o, REQA);
      tick(); chk("R8 burst +1 step", addr_o, REQA + s);
      tick(); chk("R8 burst +2 steps", addr_o, REQA + 2 * s);
      tick();
    end
    go(6'd32, 1'b0); tick(); tick();
    chk("R9 non-burst no step", addr_o, REQA);
    tick();

    // R12 wait freeze, R11 no freeze when line 4 is a plain output
    wr(6'd40, 14'h0011); wr(6'd41, 14'h3002);
    mode_g4dis_i = 1'b1; go(6'd40, 1'b0); wait_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R12 frozen outputs", {strb_n_o, ack_n_o, gpl4_o}, {4'h1, 1'b0, 1'b1});
    end
    wait_i = 1'b0; tick();
    chk("R12 resumes", strb_n_o, 4'h2);
    tick();
    mode_g4dis_i = 1'b0; go(6'd40, 1'b0);
    chk("R11 gpl4 value", gpl4_o, 1'b1);
    wait_i = 1'b1; tick(); wait_i = 1'b0;
    chk("R11 wait not enabled", strb_n_o, 4'h2);
    tick(); idle_chk("R1 idle at end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule